// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the three timing signals of a stereo serial audio port: an oversampling root tick, a bit clock and a frame (left/right) clock. Two source clock ticks come in as single-cycle enables on the system clock. A mode bit picks one of them. An optional prescaler then divides the chosen source down to the root rate. The bit clock and the frame clock are then counted off the root tick. All outputs are registered levels or pulses in the system clock domain, so downstream serializers can sample them as enables.

The ratios come from the mode image. The root clock can be 256, 512, 384 or 768 times the frame rate, and a frame can hold 32, 48, 16 or 24 bit clocks. A new ratio pair is taken over only at the start of a frame, so no shortened clock pulse appears. A pair that cannot be divided evenly is flagged and never used. The same holds for a 24-bit sample length combined with a power-of-two root ratio. In slave mode the generator is held idle, and the external bit and frame clocks are passed straight to the outputs.

Top module: `ack_clkgen`

## Requirements
- R1: After reset, bclk_o, lrclk_o, frame_o and cfg_err_o are low and the active ratio pair is 256 fs root with 32 bit clocks per frame.
- R2: Root ratio code mode_i[1:0] selects the frame length in root ticks: 0 gives 256, 1 gives 512, 2 gives 384, 3 gives 768.
- R3: Bit ratio code mode_i[3:2] selects the bit clocks per frame: 0 gives 32, 1 gives 48, 2 gives 16, 3 gives 24. bclk_o is high for exactly (root/bits)/2 root ticks and then low for the same number of ticks.
- R4: lrclk_o is low for the first half of each frame and high for the second half. It changes only on a falling edge of bclk_o.
- R5: When psr_i[15] is 1, one root tick is produced for every (psr_i[14:8] + 1) source ticks.
- R6: When psr_i[15] is 0, every source tick becomes a root tick, whatever value psr_i[14:8] holds.
- R7: mode_i[6] selects the source: 0 uses src0_tick_i and 1 uses src1_tick_i.
- R8: cfg_err_o goes high in the cycle after the mode changes, when the root ratio is not a whole multiple of the bit ratio. This happens with root code 0 or 1 together with bit code 1 or 3.
- R9: cfg_err_o goes high when the sample length code mode_i[5:4] is 2 (24-bit) and the root code is 0 or 1. A 24-bit length with root code 2 or 3 raises no error.
- R10: An illegal setting is never adopted. The previously active ratio pair keeps running.
- R11: A ratio change written in the middle of a frame does not alter that frame. It takes effect from the next frame start.
- R12: With mode_i[7] set (slave), bclk_o and lrclk_o follow ext_bclk_i and ext_lrclk_i. root_tick_o and frame_o stay low, and cfg_err_o stays low even for an illegal ratio pair.
- R13: frame_o is a one-cycle pulse in the cycle where a frame begins. In that cycle bclk_o and lrclk_o are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 8 | Mode image: [1:0] root code, [3:2] bit code, [5:4] sample length, [6] source select, [7] slave |
| psr_i | input | 8 | Prescaler image bits 15:8: [15] enable, [14:8] divide minus one |
| src0_tick_i | input | 1 | Source clock 0 tick enable |
| src1_tick_i | input | 1 | Source clock 1 tick enable |
| ext_bclk_i | input | 1 | External bit clock for slave mode |
| ext_lrclk_i | input | 1 | External frame clock for slave mode |
| root_tick_o | output | 1 | One pulse per root clock period |
| bclk_o | output | 1 | Bit clock level |
| lrclk_o | output | 1 | Frame clock level (low = left half) |
| frame_o | output | 1 | Frame start pulse |
| cfg_err_o | output | 1 | Illegal ratio setting flag |

## Verification
A ratio write and a frame boundary can both affect the active pair at the same moment. The bench writes a new pair partway into a frame and checks two things: the frame that ends next keeps its old length, and the frame after it has the new one. The bench also leaves an illegal pair on the port across several frame boundaries. In that case adoption and rejection would both land on the same edge, and the frame length must stay at the last legal value while the error flag is high.

// File: rtl/ack_pkg.sv
package ack_pkg;
  localparam int MODE_W = 8;
  localparam int M_RC   = 0;
  localparam int M_BC   = 2;
  localparam int M_LEN  = 4;
  localparam int M_SEL  = 6;
  localparam int M_SLV  = 7;
  localparam logic [1:0] LEN_24 = 2'd2;

  typedef struct packed {
    logic [1:0] rc;
    logic [1:0] bc;
  } ratio_t;

  // root clock periods per frame for a root code
  function automatic logic [9:0] root_fs(input logic [1:0] c);
    case (c)
      2'd0:    return 10'd256;
      2'd1:    return 10'd512;
      2'd2:    return 10'd384;
      default: return 10'd768;
    endcase
  endfunction

  // bit clock periods per frame for a bit code
  function automatic logic [5:0] bit_fs(input logic [1:0] c);
    case (c)
      2'd0:    return 6'd32;
      2'd1:    return 6'd48;
      2'd2:    return 6'd16;
      default: return 6'd24;
    endcase
  endfunction

  // the bit period must be a whole number of root periods
  function automatic logic pair_ok(input ratio_t r);
    logic [9:0] rem;
    rem = root_fs(r.rc) % {4'd0, bit_fs(r.bc)};
    return (rem == 10'd0);
  endfunction

  // root ticks per bit clock half period
  function automatic logic [5:0] half_ticks(input ratio_t r);
    logic [9:0] q;
    q = root_fs(r.rc) / {4'd0, bit_fs(r.bc)};
    return q[6:1];
  endfunction

  // 24-bit samples need a root ratio that is a multiple of three
  function automatic logic len_ok(input logic [1:0] rc, input logic [1:0] len);
    return !((len == LEN_24) && (rc[1] == 1'b0));
  endfunction
endpackage

// File: rtl/ack_prescale.sv
module ack_prescale #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src0_tick,
  input  logic             src1_tick,
  input  logic             src_sel,
  input  logic             psr_en,
  input  logic [DIV_W-1:0] psr_div,
  input  logic             hold,
  output logic             root_tick
);
  logic [DIV_W-1:0] cnt;
  logic             sel_tick;
  logic             div_done;

  assign sel_tick = src_sel ? src1_tick : src0_tick;
  assign div_done = (cnt >= psr_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      root_tick <= 1'b0;
    end else if (hold) begin
      cnt       <= '0;
      root_tick <= 1'b0;
    end else if (sel_tick) begin
      if (!psr_en) begin
        cnt       <= '0;
        root_tick <= 1'b1;
      end else if (div_done) begin
        cnt       <= '0;
        root_tick <= 1'b1;
      end else begin
        cnt       <= cnt + 1'b1;
        root_tick <= 1'b0;
      end
    end else begin
      root_tick <= 1'b0;
    end
  end

  // R5: a root tick always follows a selected source tick
  a_r5_tick_from_source: assert property (@(posedge clk) disable iff (!rst_n)
    root_tick |-> $past(sel_tick));

  // R6: with the prescaler off every source tick passes
  a_r6_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(psr_en) && $past(sel_tick) && !$past(hold)) |-> root_tick);
endmodule

// File: rtl/ack_ratio_chk.sv
module ack_ratio_chk (
  input  logic             slave,
  input  logic [1:0]       rc,
  input  logic [1:0]       bc,
  input  logic [1:0]       len,
  output ack_pkg::ratio_t  pend,
  output logic             legal,
  output logic             err
);
  logic pair_good;
  logic len_good;

  always_comb begin
    pend.rc   = rc;
    pend.bc   = bc;
    pair_good = ack_pkg::pair_ok(pend);
    len_good  = ack_pkg::len_ok(rc, len);
    legal     = pair_good && len_good;
    err       = !slave && !legal;
  end
endmodule

// File: rtl/ack_frame_gen.sv
module ack_frame_gen (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            root_tick,
  input  logic            hold,
  input  ack_pkg::ratio_t pend,
  input  logic            pend_ok,
  output logic            bclk_q,
  output logic            lr_q,
  output logic            frame_q,
  output ack_pkg::ratio_t act
);
  logic [5:0] hcnt;
  logic [5:0] bitcnt;
  logic [5:0] half;
  logic [5:0] bits;
  logic       half_done;
  logic       bfall;
  logic       wrap;
  logic       mid;

  always_comb begin
    half      = ack_pkg::half_ticks(act);
    bits      = ack_pkg::bit_fs(act.bc);
    half_done = root_tick && (hcnt == half - 6'd1);
    bfall     = half_done && bclk_q;
    wrap      = bfall && (bitcnt == bits - 6'd1);
    mid       = bfall && (bitcnt == (bits >> 1) - 6'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt    <= '0;
      bitcnt  <= '0;
      bclk_q  <= 1'b0;
      lr_q    <= 1'b0;
      frame_q <= 1'b0;
      act     <= '0;
    end else if (hold) begin
      hcnt    <= '0;
      bitcnt  <= '0;
      bclk_q  <= 1'b0;
      lr_q    <= 1'b0;
      frame_q <= 1'b0;
      if (pend_ok) act <= pend;
    end else begin
      frame_q <= wrap;
      if (root_tick) hcnt <= half_done ? 6'd0 : hcnt + 6'd1;
      if (half_done) bclk_q <= ~bclk_q;
      if (bfall) begin
        if (wrap) begin
          bitcnt <= '0;
          lr_q   <= 1'b0;
          if (pend_ok) act <= pend;
        end else begin
          bitcnt <= bitcnt + 6'd1;
          if (mid) lr_q <= 1'b1;
        end
      end
    end
  end

  // R3: the bit clock moves only on a root tick
  a_r3_bclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(bclk_q) && !$past(hold)) |-> $past(root_tick));

  // R4: the frame clock moves only with a falling bit clock
  a_r4_lr_on_bclk_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(lr_q) && !$past(hold)) |-> $fell(bclk_q));

  // R11: the active pair changes only at a frame start
  a_r11_cfg_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act) && !$past(hold)) |-> frame_q);

  // R13: a frame begins with both clocks low and the bit count cleared
  a_r13_frame_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q |-> (!lr_q && !bclk_q && (bitcnt == 6'd0)));

  // R10: the running pair is always an evenly dividing one
  a_r10_act_legal: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pkg::pair_ok(act));
endmodule

// File: rtl/ack_clkgen.sv
module ack_clkgen #(
  parameter int DIV_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] mode_i,
  input  logic [7:0] psr_i,
  input  logic       src0_tick_i,
  input  logic       src1_tick_i,
  input  logic       ext_bclk_i,
  input  logic       ext_lrclk_i,
  output logic       root_tick_o,
  output logic       bclk_o,
  output logic       lrclk_o,
  output logic       frame_o,
  output logic       cfg_err_o
);
  import ack_pkg::*;

  localparam int EN_BIT = 7;

  logic            slave;
  logic            psr_en;
  logic [DIV_W-1:0] psr_div;
  logic            root_tick;
  ratio_t          pend;
  ratio_t          act;
  logic            legal;
  logic            gen_bclk;
  logic            gen_lr;
  logic            gen_frame;

  assign slave   = mode_i[M_SLV];
  assign psr_en  = psr_i[EN_BIT];
  assign psr_div = psr_i[DIV_W-1:0];

  ack_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .src0_tick (src0_tick_i),
    .src1_tick (src1_tick_i),
    .src_sel   (mode_i[M_SEL]),
    .psr_en    (psr_en),
    .psr_div   (psr_div),
    .hold      (slave),
    .root_tick (root_tick)
  );

  ack_ratio_chk u_chk (
    .slave (slave),
    .rc    (mode_i[M_RC +: 2]),
    .bc    (mode_i[M_BC +: 2]),
    .len   (mode_i[M_LEN +: 2]),
    .pend  (pend),
    .legal (legal),
    .err   (cfg_err_o)
  );

  ack_frame_gen u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .root_tick (root_tick),
    .hold      (slave),
    .pend      (pend),
    .pend_ok   (legal),
    .bclk_q    (gen_bclk),
    .lr_q      (gen_lr),
    .frame_q   (gen_frame),
    .act       (act)
  );

  assign root_tick_o = root_tick;
  assign frame_o     = gen_frame;
  assign bclk_o      = slave ? ext_bclk_i  : gen_bclk;
  assign lrclk_o     = slave ? ext_lrclk_i : gen_lr;

  // R12: a settled slave mode produces no local ticks or frame pulses
  a_r12_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (slave && $past(slave)) |-> (!root_tick_o && !frame_o));

  // R10: an illegal setting on the port never becomes the running pair
  a_r10_no_illegal_adopt: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(legal) && !$stable(act)) |-> (act != $past(pend)));
endmodule

// File: tb/sim_ack_clkgen.sv
module sim_ack_clkgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mode_r = 8'h00;
  logic [7:0] psr_r = 8'h00;
  logic       src0 = 1'b1;
  logic       src1 = 1'b0;
  logic       ext_b = 1'b0;
  logic       ext_l = 1'b0;
  logic       root_tick_o, bclk_o, lrclk_o, frame_o, cfg_err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int    q_len[$];
  int    q_bh[$];
  int    q_lh[$];
  string q_tag[$];

  int cyc = 0;
  int brun = 0;
  int bmax = 0;
  int lh = 0;

  always #5 clk = ~clk;

  ack_clkgen u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_r),
    .psr_i       (psr_r),
    .src0_tick_i (src0),
    .src1_tick_i (src1),
    .ext_bclk_i  (ext_b),
    .ext_lrclk_i (ext_l),
    .root_tick_o (root_tick_o),
    .bclk_o      (bclk_o),
    .lrclk_o     (lrclk_o),
    .frame_o     (frame_o),
    .cfg_err_o   (cfg_err_o)
  );

  // source 1 ticks on every second clock
  always @(negedge clk) src1 <= ~src1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input logic [1:0] r, input logic [1:0] b,
                                     input logic [1:0] l, input logic s, input logic sl);
    return {sl, s, l, b, r};
  endfunction

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  // monitor: measures each completed frame and scores it against the queue
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (bclk_o) begin
        brun++;
        if (brun > bmax) bmax = brun;
      end else brun = 0;
      if (lrclk_o) lh++;
      if (frame_o) begin
        if (q_len.size() > 0) begin
          int    el, eb, elh;
          string t;
          el = q_len.pop_front();
          eb = q_bh.pop_front();
          elh = q_lh.pop_front();
          t = q_tag.pop_front();
          chk(cyc == el, {t, " frame length"}, cyc, el);
          chk(bmax == eb, {t, " bclk high time"}, bmax, eb);
          chk(lh == elh, {t, " lrclk high time"}, lh, elh);
        end
        cyc = 0;
        bmax = 0;
        brun = 0;
        lh = 0;
      end
    end
  end

  task automatic wait_frames(input int n);
    repeat (n) begin
      @(negedge clk);
      while (!frame_o) @(negedge clk);
    end
  endtask

  task automatic push(input int l, input int b, input int h, input string t);
    q_len.push_back(l);
    q_bh.push_back(b);
    q_lh.push_back(h);
    q_tag.push_back(t);
  endtask

  task automatic run_cfg(input logic [7:0] m, input logic [7:0] p,
                         input int l, input int b, input int h, input string t);
    mode_r = m;
    psr_r  = p;
    wait_frames(2);
    @(posedge clk);
    push(l, b, h, t);
    wait_frames(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(bclk_o == 1'b0, "R1 bclk after reset", bclk_o, 0);
    chk(lrclk_o == 1'b0, "R1 lrclk after reset", lrclk_o, 0);
    chk(frame_o == 1'b0, "R1 frame after reset", frame_o, 0);
    chk(cfg_err_o == 1'b0, "R1 error after reset", cfg_err_o, 0);

    // R1 R2 R3 R4 default 256/32
    run_cfg(mk(2'd0, 2'd0, 2'd0, 1'b0, 1'b0), 8'h00, 256, 4, 128, "R1 R4 default");
    run_cfg(mk(2'd2, 2'd1, 2'd0, 1'b0, 1'b0), 8'h00, 384, 4, 192, "R2 R3 384/48");
    run_cfg(mk(2'd3, 2'd3, 2'd0, 1'b0, 1'b0), 8'h00, 768, 16, 384, "R2 R3 768/24");
    run_cfg(mk(2'd1, 2'd2, 2'd0, 1'b0, 1'b0), 8'h00, 512, 16, 256, "R2 R3 512/16");
    run_cfg(mk(2'd2, 2'd0, 2'd0, 1'b0, 1'b0), 8'h00, 384, 6, 192, "R2 R3 384/32");

    // R8 uneven pair flagged, R10 it is not adopted
    mode_r = mk(2'd0, 2'd1, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    chk(cfg_err_o == 1'b1, "R8 error for 256/48", cfg_err_o, 1);
    run_cfg(mode_r, 8'h00, 384, 6, 192, "R10 illegal pair kept out");

    // R9 24-bit length with 512 root
    mode_r = mk(2'd1, 2'd0, 2'd2, 1'b0, 1'b0);
    @(negedge clk);
    chk(cfg_err_o == 1'b1, "R9 error for 24-bit at 512", cfg_err_o, 1);
    run_cfg(mode_r, 8'h00, 384, 6, 192, "R9 R10 illegal length kept out");
    mode_r = mk(2'd2, 2'd3, 2'd2, 1'b0, 1'b0);
    @(negedge clk);
    chk(cfg_err_o == 1'b0, "R9 no error for 24-bit at 384", cfg_err_o, 0);
    run_cfg(mode_r, 8'h00, 384, 8, 192, "R9 384/24 24-bit");

    // R5 prescaler divide by two, R6 disabled value ignored
    run_cfg(mk(2'd0, 2'd0, 2'd0, 1'b0, 1'b0), 8'h81, 512, 8, 256, "R5 prescale by 2");
    run_cfg(mk(2'd0, 2'd0, 2'd0, 1'b0, 1'b0), 8'h03, 256, 4, 128, "R6 prescaler off");
    // R7 source 1 ticks every second cycle
    run_cfg(mk(2'd0, 2'd0, 2'd0, 1'b1, 1'b0), 8'h00, 512, 8, 256, "R7 source 1");
    run_cfg(mk(2'd0, 2'd0, 2'd0, 1'b0, 1'b0), 8'h00, 256, 4, 128, "R7 source 0");

    // R11 change written mid-frame
    wait_frames(1);
    repeat (40) @(negedge clk);
    mode_r = mk(2'd2, 2'd1, 2'd0, 1'b0, 1'b0);
    @(posedge clk);
    push(256, 4, 128, "R11 frame in progress keeps old ratio");
    wait_frames(1);
    @(posedge clk);
    push(384, 4, 192, "R11 next frame uses new ratio");
    wait_frames(1);

    // R13 pulse width and levels at frame start
    wait_frames(1);
    chk(bclk_o == 1'b0, "R13 bclk low at frame start", bclk_o, 0);
    chk(lrclk_o == 1'b0, "R13 lrclk low at frame start", lrclk_o, 0);
    @(negedge clk);
    chk(frame_o == 1'b0, "R13 frame pulse one cycle", frame_o, 0);

    // R12 slave pass-through
    mode_r = mk(2'd0, 2'd1, 2'd0, 1'b0, 1'b1);
    ext_b = 1'b1;
    ext_l = 1'b0;
    @(negedge clk);
    chk(bclk_o == 1'b1, "R12 bclk follows external", bclk_o, 1);
    chk(lrclk_o == 1'b0, "R12 lrclk follows external", lrclk_o, 0);
    chk(cfg_err_o == 1'b0, "R12 no error in slave", cfg_err_o, 0);
    ext_b = 1'b0;
    ext_l = 1'b1;
    @(negedge clk);
    chk(bclk_o == 1'b0, "R12 bclk follows external low", bclk_o, 0);
    chk(lrclk_o == 1'b1, "R12 lrclk follows external high", lrclk_o, 1);
    begin
      int busy = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (root_tick_o || frame_o) busy++;
      end
      chk(busy == 0, "R12 no ticks or frames in slave", busy, 0);
    end
    ext_l = 1'b0;

    // back to master with a legal pair
    run_cfg(mk(2'd1, 2'd0, 2'd0, 1'b0, 1'b0), 8'h00, 512, 8, 256, "R2 R12 after slave 512/32");

    done = 1'b1;
    report();
    $finish;
  end
endmodule